// File: doc/BRIEF.md
# Circular Endpoint Buffer Engine

This block carries one endpoint's data between a packet-side word stream and a ring buffer that lives in a shared, word-addressed memory. The ring is described by an 18-bit base address and a 16-bit size. Two 16-bit offsets are measured from that base: a read offset and a write offset. Every memory access moves one 16-bit word, so a 64-byte packet occupies 32 words. The transfer direction decides which side moves which offset. For outbound-to-device (OUT) traffic the engine fills the ring and moves the write offset, while a processor drains it and moves the read offset. For IN traffic the roles swap.

Each offset names the last word touched. To access a word, the engine first advances the offset, wrapping from size-1 back to 0, and then uses the new value, added to the base, as the memory address. The ring reads empty when the two offsets are equal. It reads full when advancing the write offset would make it equal the read offset, so one slot always stays unused.

A processor reads and writes the offsets through a small register port. In any cycle with a register access pending, all memory traffic is held off. The engine raises sticky flags when an OUT packet meets a full ring (overflow, meaning the packet should be refused) or when an IN request meets an empty ring (underrun). It also flags a ring that does not fit the address space.

Top module: `epbuf_engine`

## Requirements
- R1: After reset both offsets read 0, `buf_empty` is 1, and `buf_full`, `buf_ovf`, `buf_udr` and `mem_req` are 0.
- R2: Each memory access addresses `cfg_base` plus the advanced offset. After the access that offset holds the advanced value, which is the last word touched. One 16-bit word moves per access.
- R3: An offset equal to `cfg_size`-1 advances to 0.
- R4: `buf_empty` is 1 exactly when the read offset equals the write offset. `buf_full` is 1 exactly when the advanced write offset equals the read offset.
- R5: With `dir_in`=0 (OUT), `pkt_ready` is 1 when the configuration is valid, no register access is pending, the ring is not full and `buf_ovf` is clear. A word offered with `pkt_valid` while ready is written to memory and advances the write offset.
- R6: With `dir_in`=1 (IN), a `pkt_rd_req` on a non-empty ring with no register access pending issues a memory read and advances the read offset. `pkt_rvalid` is 1 in the next cycle, and `pkt_rdata` then carries the word at that address.
- R7: `reg_rdata` shows the read offset when `reg_sel`=0 and the write offset when `reg_sel`=1. A register write (`reg_req`=1, `reg_wr`=1) loads `reg_wdata` into the selected offset from the next cycle, but only if the processor owns that offset: the read offset when `dir_in`=0, the write offset when `dir_in`=1. A write to the offset the engine owns leaves it unchanged.
- R8: In a cycle with `reg_req`=1, `mem_req` is 0 and neither offset is advanced by the engine.
- R9: In OUT mode, a word offered while the ring is full (valid configuration, no register access) sets `buf_ovf`. The flag stays set, and `pkt_ready` stays low, until a `pkt_start` pulse clears it.
- R10: In IN mode, a `pkt_rd_req` while the ring is empty (valid configuration, no register access) sets `buf_udr`, which stays set until a `pkt_start` pulse, and no memory access is made.
- R11: `cfg_err` is 1 when `cfg_size` is below 2 or `cfg_base`+`cfg_size` exceeds 2^18. While it is set, no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 18 | Ring base word address |
| cfg_size | input | 16 | Ring size in words |
| dir_in | input | 1 | 0 = OUT (engine fills), 1 = IN (engine drains) |
| cfg_err | output | 1 | Ring does not fit or is too small |
| reg_req | input | 1 | Processor register access this cycle |
| reg_wr | input | 1 | Access is a write |
| reg_sel | input | 1 | 0 = read offset, 1 = write offset |
| reg_wdata | input | 16 | Offset value to load |
| reg_rdata | output | 16 | Selected offset value |
| pkt_start | input | 1 | Start of a new packet; clears sticky flags |
| pkt_valid | input | 1 | OUT word offered |
| pkt_wdata | input | 16 | OUT word |
| pkt_ready | output | 1 | OUT word accepted this cycle |
| pkt_rd_req | input | 1 | IN word requested |
| pkt_rvalid | output | 1 | IN word returned |
| pkt_rdata | output | 16 | IN word |
| buf_empty | output | 1 | Ring empty |
| buf_full | output | 1 | Ring full |
| buf_ovf | output | 1 | Sticky overflow (packet to be refused) |
| buf_udr | output | 1 | Sticky underrun |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read |

## Verification
A directed OUT run fills an 8-word ring until it is full and then offers one more word. This separates the one-empty-slot full rule from an off-by-one rule, and it shows that overflow is sticky. A processor move of the read offset, made together with offered words, then lets the write offset wrap past the end. That step tells stalling apart from accepting, and wrapping apart from running past the ring. The IN run drains the same data, so any mismatch in address or ordering shows up in the returned words, and an extra request exposes underrun. A long pseudo-random phase then mixes direction flips, register reads and writes to owned and foreign offsets, bad configurations and stream traffic. It compares every output against a behavioural model on every clock.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
   typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} dir_e;
   localparam int PTR_RD = 0;
   localparam int PTR_WR = 1;
   localparam int NPTR   = 2;
   typedef struct packed {
      logic empty;
      logic full;
   } occ_t;
endpackage

// File: rtl/epbuf_ptr.sv
module epbuf_ptr #(
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFS_W-1:0] size,
   input  logic             eng_own,
   input  logic             eng_step,
   input  logic             cpu_load,
   input  logic [OFS_W-1:0] cpu_val,
   output logic [OFS_W-1:0] ofs,
   output logic [OFS_W-1:0] ofs_inc
);
   localparam logic [OFS_W-1:0] ONE = 1;

   always_comb begin
      if (ofs == size - ONE) ofs_inc = '0;
      else                   ofs_inc = ofs + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs <= '0;
      end else if (eng_own) begin
         if (eng_step) ofs <= ofs_inc;
      end else if (cpu_load) begin
         ofs <= cpu_val;
      end
   end
endmodule

// File: rtl/epbuf_cfgchk.sv
module epbuf_cfgchk #(
   parameter int ADDR_W = 18,
   parameter int OFS_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  size,
   output logic              err
);
   localparam logic [ADDR_W:0]  LIMIT  = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [OFS_W-1:0] MIN_SZ = 2;

   logic [ADDR_W:0] size_ext;
   logic [ADDR_W:0] ring_end;

   always_comb begin
      size_ext = {{(ADDR_W + 1 - OFS_W){1'b0}}, size};
      ring_end = {1'b0, base} + size_ext;
      err      = (size < MIN_SZ) || (ring_end > LIMIT);
   end
endmodule

// File: rtl/epbuf_occ.sv
module epbuf_occ
   import epbuf_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic [OFS_W-1:0] rd_ofs,
   input  logic [OFS_W-1:0] wr_ofs,
   input  logic [OFS_W-1:0] wr_inc,
   output occ_t             occ
);
   always_comb begin
      occ.empty = (rd_ofs == wr_ofs);
      occ.full  = (wr_inc == rd_ofs);
   end
endmodule

// File: rtl/epbuf_engine.sv
module epbuf_engine
   import epbuf_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int OFS_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [OFS_W-1:0]  cfg_size,
   input  logic              dir_in,
   output logic              cfg_err,
   input  logic              reg_req,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [OFS_W-1:0]  reg_wdata,
   output logic [OFS_W-1:0]  reg_rdata,
   input  logic              pkt_start,
   input  logic              pkt_valid,
   input  logic [DATA_W-1:0] pkt_wdata,
   output logic              pkt_ready,
   input  logic              pkt_rd_req,
   output logic              pkt_rvalid,
   output logic [DATA_W-1:0] pkt_rdata,
   output logic              buf_empty,
   output logic              buf_full,
   output logic              buf_ovf,
   output logic              buf_udr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int PAD_W = ADDR_W - OFS_W;

   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_bad_data_w
      $error("epbuf_engine: memory words must be 16 bits wide");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("epbuf_engine: address must be wider than an offset");
   end
   if (OFS_W < 2) begin : g_bad_ofs_w
      $error("epbuf_engine: offset width too small");
   end

   dir_e             dir;
   occ_t             occ;
   logic             run_ok;
   logic             cpu_load;
   logic             wr_fire;
   logic             rd_fire;
   logic             ovf_evt;
   logic             udr_evt;
   logic             ovf_q;
   logic             udr_q;
   logic             rvalid_q;
   logic [OFS_W-1:0] ofs_q   [NPTR];
   logic [OFS_W-1:0] inc_q   [NPTR];
   logic [OFS_W-1:0] rd_ofs;
   logic [OFS_W-1:0] wr_ofs;
   logic [OFS_W-1:0] acc_ofs;

   assign dir = dir_e'(dir_in);

   epbuf_cfgchk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cfgchk (
      .base (cfg_base),
      .size (cfg_size),
      .err  (cfg_err)
   );

   // one offset register per ring end; ownership follows direction
   for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
      logic own;
      logic step;
      logic load;
      if (gi == PTR_WR) begin : g_wr
         assign own  = (dir == DIR_OUT);
         assign step = wr_fire;
         assign load = cpu_load && reg_sel;
      end else begin : g_rd
         assign own  = (dir == DIR_IN);
         assign step = rd_fire;
         assign load = cpu_load && !reg_sel;
      end
      epbuf_ptr #(.OFS_W(OFS_W)) u_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .size     (cfg_size),
         .eng_own  (own),
         .eng_step (step),
         .cpu_load (load),
         .cpu_val  (reg_wdata),
         .ofs      (ofs_q[gi]),
         .ofs_inc  (inc_q[gi])
      );
   end

   assign rd_ofs = ofs_q[PTR_RD];
   assign wr_ofs = ofs_q[PTR_WR];

   epbuf_occ #(.OFS_W(OFS_W)) u_occ (
      .rd_ofs (rd_ofs),
      .wr_ofs (wr_ofs),
      .wr_inc (inc_q[PTR_WR]),
      .occ    (occ)
   );

   always_comb begin
      run_ok    = !cfg_err && !reg_req;
      cpu_load  = reg_req && reg_wr;
      pkt_ready = (dir == DIR_OUT) && run_ok && !occ.full && !ovf_q;
      wr_fire   = pkt_valid && pkt_ready;
      ovf_evt   = (dir == DIR_OUT) && run_ok && pkt_valid && occ.full;
      rd_fire   = (dir == DIR_IN) && run_ok && pkt_rd_req && !occ.empty;
      udr_evt   = (dir == DIR_IN) && run_ok && pkt_rd_req && occ.empty;
      acc_ofs   = wr_fire ? inc_q[PTR_WR] : inc_q[PTR_RD];
      mem_req   = wr_fire || rd_fire;
      mem_we    = wr_fire;
      mem_addr  = cfg_base + {{PAD_W{1'b0}}, acc_ofs};
      mem_wdata = pkt_wdata;
      reg_rdata = reg_sel ? wr_ofs : rd_ofs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q    <= 1'b0;
         udr_q    <= 1'b0;
         rvalid_q <= 1'b0;
      end else begin
         ovf_q    <= (ovf_q && !pkt_start) || ovf_evt;
         udr_q    <= (udr_q && !pkt_start) || udr_evt;
         rvalid_q <= rd_fire;
      end
   end

   assign buf_empty  = occ.empty;
   assign buf_full   = occ.full;
   assign buf_ovf    = ovf_q;
   assign buf_udr    = udr_q;
   assign pkt_rvalid = rvalid_q;
   assign pkt_rdata  = mem_rdata;
endmodule

// File: rtl/epbuf_engine_chk.sv
module epbuf_engine_chk #(
   parameter int ADDR_W = 18,
   parameter int OFS_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_req,
   input logic              dir_in,
   input logic              cfg_err,
   input logic [ADDR_W-1:0] cfg_base,
   input logic              pkt_start,
   input logic              buf_full,
   input logic              buf_empty,
   input logic              buf_ovf,
   input logic              buf_udr,
   input logic              pkt_ready,
   input logic              pkt_rvalid,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [OFS_W-1:0]  wr_ofs,
   input logic [OFS_W-1:0]  rd_ofs
);
   localparam int PAD_W = ADDR_W - OFS_W;

   // R8
   stall_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |-> !mem_req);

   // R11
   cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !mem_req);

   // R5
   full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && buf_full) |-> (!mem_we && !pkt_ready));

   // R10
   empty_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && buf_empty) |-> !mem_req);

   // R2
   wr_addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=>
         (!$stable(cfg_base) || (cfg_base + {{PAD_W{1'b0}}, wr_ofs} == $past(mem_addr))));

   // R2
   rd_addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=>
         (!$stable(cfg_base) || (cfg_base + {{PAD_W{1'b0}}, rd_ofs} == $past(mem_addr))));

   // R6
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> pkt_rvalid);

   // R6
   rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && !mem_we) |=> !pkt_rvalid);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_ovf && !pkt_start) |=> buf_ovf);

   // R10
   udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_udr && !pkt_start) |=> buf_udr);

   // R4
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> !(buf_full && buf_empty));
endmodule

bind epbuf_engine epbuf_engine_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_req    (reg_req),
   .dir_in     (dir_in),
   .cfg_err    (cfg_err),
   .cfg_base   (cfg_base),
   .pkt_start  (pkt_start),
   .buf_full   (buf_full),
   .buf_empty  (buf_empty),
   .buf_ovf    (buf_ovf),
   .buf_udr    (buf_udr),
   .pkt_ready  (pkt_ready),
   .pkt_rvalid (pkt_rvalid),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .wr_ofs     (wr_ofs),
   .rd_ofs     (rd_ofs)
);

// File: tb/epbuf_engine_bench.sv
module epbuf_engine_bench;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] cfg_base;
   logic [15:0] cfg_size;
   logic        dir_in;
   logic        cfg_err;
   logic        reg_req, reg_wr, reg_sel;
   logic [15:0] reg_wdata, reg_rdata;
   logic        pkt_start, pkt_valid, pkt_ready, pkt_rd_req, pkt_rvalid;
   logic [15:0] pkt_wdata, pkt_rdata;
   logic        buf_empty, buf_full, buf_ovf, buf_udr;
   logic        mem_req, mem_we;
   logic [17:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   // behavioural model state
   int          m_rd, m_wr;
   bit          m_ovf, m_udr;
   logic [15:0] smem [int];
   logic [15:0] dmem [int];

   always #(CLK_PER/2) clk = ~clk;

   epbuf_engine u_epbuf_engine (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .dir_in(dir_in), .cfg_err(cfg_err), .reg_req(reg_req), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pkt_start(pkt_start), .pkt_valid(pkt_valid), .pkt_wdata(pkt_wdata),
      .pkt_ready(pkt_ready), .pkt_rd_req(pkt_rd_req), .pkt_rvalid(pkt_rvalid),
      .pkt_rdata(pkt_rdata), .buf_empty(buf_empty), .buf_full(buf_full),
      .buf_ovf(buf_ovf), .buf_udr(buf_udr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // shared memory model: write on the edge, registered read
   always @(posedge clk) begin
      if (mem_req && mem_we) dmem[int'(mem_addr)] = mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 16'h0;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int inc(input int x);
      return (x == int'(cfg_size) - 1) ? 0 : x + 1;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   // one clock: compare combinational outputs, advance the model, compare read return
   task automatic cycle();
      bit err, ok, full, empty, ready, wf, rf, oevt, uevt;
      int addr;
      logic [15:0] exp_rd;
      #1;
      err   = (cfg_size < 2) || (int'(cfg_base) + int'(cfg_size) > 262144);
      ok    = !err && !reg_req;
      full  = inc(m_wr) == m_rd;
      empty = m_wr == m_rd;
      ready = !dir_in && ok && !full && !m_ovf;
      wf    = pkt_valid && ready;
      rf    = dir_in && ok && pkt_rd_req && !empty;
      oevt  = !dir_in && ok && pkt_valid && full;
      uevt  = dir_in && ok && pkt_rd_req && empty;
      addr  = int'(cfg_base) + (wf ? inc(m_wr) : inc(m_rd));
      chk("R11 cfg_err", cfg_err, err);
      chk("R4 full", buf_full, full);
      chk("R4 empty", buf_empty, empty);
      chk("R5 pkt_ready", pkt_ready, ready);
      chk("R8 mem_req", mem_req, wf || rf);
      if (wf || rf) begin
         chk("R2 mem_we", mem_we, wf);
         chk("R2 mem_addr", mem_addr, addr);
      end
      if (wf) chk("R5 mem_wdata", mem_wdata, pkt_wdata);
      chk("R9 buf_ovf", buf_ovf, m_ovf);
      chk("R10 buf_udr", buf_udr, m_udr);
      chk("R7 reg_rdata", reg_rdata, reg_sel ? m_wr : m_rd);
      exp_rd = '0;
      if (rf) exp_rd = smem.exists(addr) ? smem[addr] : 16'h0;
      @(posedge clk);
      if (wf) begin smem[addr] = pkt_wdata; m_wr = inc(m_wr); end
      if (rf) m_rd = inc(m_rd);
      if (reg_req && reg_wr) begin
         if (reg_sel && dir_in) m_wr = int'(reg_wdata);
         if (!reg_sel && !dir_in) m_rd = int'(reg_wdata);
      end
      m_ovf = (m_ovf && !pkt_start) || oevt;
      m_udr = (m_udr && !pkt_start) || uevt;
      #1;
      chk("R6 pkt_rvalid", pkt_rvalid, rf);
      if (rf) chk("R6 pkt_rdata", pkt_rdata, exp_rd);
      @(negedge clk);
   endtask

   task automatic idle();
      reg_req = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
      pkt_start = 0; pkt_valid = 0; pkt_wdata = '0; pkt_rd_req = 0;
   endtask

   task automatic push(input logic [15:0] w);
      idle(); pkt_valid = 1; pkt_wdata = w; cycle();
   endtask

   task automatic pop();
      idle(); pkt_rd_req = 1; cycle();
   endtask

   task automatic cpu_write(input logic sel, input logic [15:0] v);
      idle(); reg_req = 1; reg_wr = 1; reg_sel = sel; reg_wdata = v; cycle();
   endtask

   task automatic cpu_read_chk(input logic sel, input int exp, input string tag);
      idle(); reg_req = 1; reg_sel = sel; #1;
      chk(tag, reg_rdata, exp);
      cycle();
   endtask

   task automatic start_pkt();
      idle(); pkt_start = 1; cycle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] lfsr;
      cfg_base = 18'h00100; cfg_size = 16'd8; dir_in = 0;
      idle();
      m_rd = 0; m_wr = 0; m_ovf = 0; m_udr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 empty", buf_empty, 1);
      chk("R1 full", buf_full, 0);
      chk("R1 ovf", buf_ovf, 0);
      chk("R1 udr", buf_udr, 0);
      chk("R1 mem_req", mem_req, 0);
      cpu_read_chk(0, 0, "R1 rd_ofs");
      cpu_read_chk(1, 0, "R1 wr_ofs");

      // OUT: fill to full (7 of 8 slots), then overflow
      for (int i = 0; i < 7; i++) push(16'hA000 + 16'(i));
      #1 chk("R4 full after 7 words", buf_full, 1);
      push(16'hAFFF);
      #1 chk("R9 ovf set on full", buf_ovf, 1);
      push(16'hAFFE);
      #1 chk("R9 ovf sticky", buf_ovf, 1);
      start_pkt();
      #1 chk("R9 ovf cleared by start", buf_ovf, 0);

      // R8: register access with a word offered stalls it
      idle(); reg_req = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 16'd5;
      pkt_valid = 1; pkt_wdata = 16'hBEEF;
      #1 chk("R8 no access during reg write", mem_req, 0);
      cycle();
      cpu_read_chk(0, 5, "R7 rd_ofs loaded");
      // R7: write to engine-owned offset is ignored
      cpu_write(1, 16'd2);
      cpu_read_chk(1, 7, "R7 foreign write ignored");
      // R3: wrap from 7 to 0
      push(16'hB000);
      cpu_read_chk(1, 0, "R3 wr_ofs wrapped");
      for (int i = 1; i < 6; i++) push(16'hB000 + 16'(i));
      cpu_read_chk(1, 4, "R5 wr_ofs after refill");

      // IN: drain all 7 words, then underrun
      dir_in = 1;
      idle(); cycle();
      for (int i = 0; i < 7; i++) pop();
      #1 chk("R4 empty after drain", buf_empty, 1);
      pop();
      #1 chk("R10 underrun set", buf_udr, 1);
      start_pkt();
      #1 chk("R10 underrun cleared", buf_udr, 0);
      // processor owns write offset in IN
      cpu_write(1, 16'd6);
      cpu_read_chk(1, 6, "R7 wr_ofs loaded in IN");
      cpu_write(0, 16'd1);
      cpu_read_chk(0, 4, "R7 rd write ignored in IN");
      pop(); pop();

      // R11 bad configurations
      cfg_base = 18'h3FFF8; cfg_size = 16'd16;
      idle(); pkt_rd_req = 1; #1 chk("R11 overrun cfg", cfg_err, 1);
      chk("R11 no access", mem_req, 0);
      cycle();
      cfg_base = 18'h3FFF0; cfg_size = 16'd16;
      idle(); #1 chk("R11 exact fit ok", cfg_err, 0);
      cycle();
      cfg_base = 18'h00100; cfg_size = 16'd1;
      idle(); #1 chk("R11 size 1", cfg_err, 1);
      cycle();
      cfg_size = 16'd8;

      // mixed pseudo-random traffic checked every clock
      lfsr = 32'h1ACE5EED;
      for (int c = 0; c < 2000; c++) begin
         idle();
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (c % 60 == 59) dir_in = ~dir_in;
         reg_req    = (lfsr[3:0] == 4'h0);
         reg_wr     = lfsr[4];
         reg_sel    = lfsr[5];
         reg_wdata  = 16'(lfsr[10:8] % 8);
         pkt_valid  = lfsr[12] | lfsr[13];
         pkt_wdata  = lfsr[31:16];
         pkt_rd_req = lfsr[14] | lfsr[15];
         pkt_start  = (lfsr[20:16] == 5'h3);
         cycle();
      end
      finish_run();
   end
endmodule